// File: doc/BRIEF.md
# Reset configuration word sequencer

This block sets up the hard reset configuration word of one processor node. It can also act as the configuration master that programs every node in the system. While power-on reset is asserted, the node watches its configuration strobe input. When power-on reset is released, the synchronised level of that strobe fixes the role of the node until the next power-on reset:

- **Low strobe:** the node becomes the master. It reads a fixed run of eight 32-bit words from boot memory, one read at a time. It places each word on its configuration data output and pulses the select line of the node that word is meant for. The master takes word 0 as its own.
- **High strobe:** the node keeps the all-zero default word. It then behaves as a slave: each low-going pulse on the strobe latches the word present on the configuration data input.

The captured word is held in a register that only power-on reset clears. A hard reset during operation restarts the sequencer control but keeps the captured word and the done flag. The node therefore comes back with the configuration it received after power-on. A handful of fields are decoded into initial values for other registers: the arbitration, memory controller, core disable and bus mode flags, and the port width of boot bank 0.

Top module: `rcw_seq`

## Requirements
- R1: Two clock cycles after power-on reset is released, the node samples its synchronised strobe. A low level makes it master and starts boot-memory reads. A high level makes it non-master: done_o rises within four cycles and no read is ever requested.
- R2: A node whose strobe stays high through power-on reset and sees no pulse holds cfg_word_o = 32'h0000_0000.
- R3: A non-master node that is done latches cfg_data_i into cfg_word_o on each low-going strobe pulse. The strobe passes through a two-stage synchroniser, so the word changes three clock edges after the falling edge.
- R4: The master issues exactly eight reads, at addresses BASE_ADDR, BASE_ADDR+1, and so on up to BASE_ADDR+7. It keeps rd_req_o high until rd_ack_i and has at most one read outstanding.
- R5: In the cycle after the read of word i is acknowledged, sel_o has only bit i set for one cycle and cfg_data_o carries word i. Bit i runs from 0 to 7 in ascending order.
- R6: The master captures word 0 (the word shown with sel_o[0]) as its own cfg_word_o.
- R7: done_o is low during power-on reset. It goes high after the eighth select pulse, or after the non-master decision, and then stays high until the next power-on reset. rst_hold_o is high exactly while done_o is low.
- R8: A hard reset leaves cfg_word_o and done_o unchanged and causes no new reads. Only power-on reset returns cfg_word_o to zero.
- R9: Word bits are numbered from the most significant bit, so bit 0 is cfg_word_o[31]. The flag outputs are: earb_o = bit 0 (cfg_word_o[31]), ext_memc_o = bit 1 ([30]), core_dis_o = bit 2 ([29]) and ext_bus_mode_o = bit 3 ([28]).
- R10: Bits 4–5 of the word, cfg_word_o[27:26], set bank0_width_o: 00 gives 64, 01 gives 8, 10 gives 16 and 11 gives 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, async assert, active low |
| hrst_n | input | 1 | Hard reset, async assert, active low |
| cfg_stb_i | input | 1 | Configuration strobe (role select, slave latch pulse) |
| cfg_data_i | input | 32 | Configuration word from the data bus (slave) |
| rd_req_o | output | 1 | Boot-memory read request |
| rd_addr_o | output | 16 | Boot-memory read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 32 | Read data |
| sel_o | output | 8 | Per-node select pulses (master) |
| cfg_data_o | output | 32 | Word presented to the selected node |
| done_o | output | 1 | Configuration complete |
| rst_hold_o | output | 1 | Hold other resets while not done |
| cfg_word_o | output | 32 | Captured configuration word |
| earb_o | output | 1 | Initial external arbitration flag |
| ext_memc_o | output | 1 | Initial external memory controller flag |
| core_dis_o | output | 1 | Initial core disable flag |
| ext_bus_mode_o | output | 1 | Initial external bus mode flag |
| bank0_width_o | output | 7 | Initial bank 0 port width in bits |

## Verification
The role is fixed two edges after power-on reset is released, and non-master done follows within the next two cycles. The bench therefore waits four cycles before it checks the role. A slave capture reaches cfg_word_o three edges after the strobe falls, and the bench checks it six cycles later while the data stays steady. During master sequencing, each select pulse appears exactly one cycle after its acknowledge. The memory model pushes the expected index and data at acknowledge time, and a monitor compares them at the falling clock edge of the pulse cycle. Done is polled cycle by cycle, with rst_hold_o checked until it rises.

// File: rtl/rcw_pkg.sv
package rcw_pkg;

  typedef enum logic [1:0] {
    ST_DECIDE = 2'd0,
    ST_REQ    = 2'd1,
    ST_SEL    = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_e;

  // port-size code to width in bits
  function automatic logic [6:0] ps_to_width(input logic [1:0] code);
    case (code)
      2'b00:   ps_to_width = 7'd64;
      2'b01:   ps_to_width = 7'd8;
      2'b10:   ps_to_width = 7'd16;
      default: ps_to_width = 7'd32;
    endcase
  endfunction

endpackage

// File: rtl/rcw_rst_sync.sv
module rcw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/rcw_fetch.sv
module rcw_fetch
  import rcw_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          AW        = 16,
  parameter int          NWORDS    = 8,
  parameter logic [AW-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              seq_rst_n,
  input  logic              por_rst_n,
  input  logic              stb_s,
  input  logic              rd_ack,
  input  logic [DW-1:0]     rd_data,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  output logic [NWORDS-1:0] sel,
  output logic [DW-1:0]     data,
  output logic              done,
  output logic              master
);
  localparam int IDXW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IDXW-1:0] LAST = IDXW'(NWORDS - 1);

  seq_state_e      state_q, state_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [DW-1:0]   buf_q;
  logic            buf_en;
  logic            done_q, done_d;
  logic            master_q, master_d;
  logic            decided_q, decided_d;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    buf_en    = 1'b0;
    done_d    = done_q;
    master_d  = master_q;
    decided_d = decided_q;
    case (state_q)
      ST_DECIDE: begin
        if (decided_q) begin
          state_d = (master_q && !done_q) ? ST_REQ : ST_DONE;
        end else begin
          decided_d = 1'b1;
          if (!stb_s) begin
            master_d = 1'b1;
            state_d  = ST_REQ;
          end else begin
            done_d  = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      ST_REQ: begin
        if (rd_ack) begin
          buf_en  = 1'b1;
          state_d = ST_SEL;
        end
      end
      ST_SEL: begin
        if (idx_q == LAST) begin
          done_d  = 1'b1;
          state_d = ST_DONE;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_REQ;
        end
      end
      default: state_d = ST_DONE;
    endcase
  end

  // sequencer state: cleared by either reset
  always_ff @(posedge clk or negedge seq_rst_n) begin
    if (!seq_rst_n) begin
      state_q <= ST_DECIDE;
      idx_q   <= '0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (buf_en) buf_q <= rd_data;
    end
  end

  // role and completion: power-on reset only, frozen during hard reset
  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      done_q    <= 1'b0;
      master_q  <= 1'b0;
      decided_q <= 1'b0;
    end else if (seq_rst_n) begin
      done_q    <= done_d;
      master_q  <= master_d;
      decided_q <= decided_d;
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_sel
    assign sel[i] = (state_q == ST_SEL) && (idx_q == IDXW'(i));
  end

  assign rd_req  = (state_q == ST_REQ);
  assign rd_addr = BASE_ADDR + AW'(idx_q);
  assign data    = buf_q;
  assign done    = done_q;
  assign master  = master_q;
endmodule

// File: rtl/rcw_decode.sv
module rcw_decode
  import rcw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word,
  output logic          earb,
  output logic          ext_memc,
  output logic          core_dis,
  output logic          ext_bus_mode,
  output logic [6:0]    bank0_width
);
  // bit n counts from the most significant end
  localparam int P_EARB = DW - 1 - 0;
  localparam int P_EXMC = DW - 1 - 1;
  localparam int P_CDIS = DW - 1 - 2;
  localparam int P_EBM  = DW - 1 - 3;
  localparam int P_PSHI = DW - 1 - 4;
  localparam int P_PSLO = DW - 1 - 5;

  assign earb         = word[P_EARB];
  assign ext_memc     = word[P_EXMC];
  assign core_dis     = word[P_CDIS];
  assign ext_bus_mode = word[P_EBM];
  assign bank0_width  = ps_to_width({word[P_PSHI], word[P_PSLO]});
endmodule

// File: rtl/rcw_seq.sv
module rcw_seq
  import rcw_pkg::*;
#(
  parameter int            DW        = 32,
  parameter int            AW        = 16,
  parameter int            NWORDS    = 8,
  parameter logic [AW-1:0] BASE_ADDR = 16'h0100
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hrst_n,
  input  logic              cfg_stb_i,
  input  logic [DW-1:0]     cfg_data_i,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic [NWORDS-1:0] sel_o,
  output logic [DW-1:0]     cfg_data_o,
  output logic              done_o,
  output logic              rst_hold_o,
  output logic [DW-1:0]     cfg_word_o,
  output logic              earb_o,
  output logic              ext_memc_o,
  output logic              core_dis_o,
  output logic              ext_bus_mode_o,
  output logic [6:0]        bank0_width_o
);
  localparam int SYNC = 2;

  logic por_rst_n, hrst_rst_n, seq_rst_n;
  logic [SYNC:0] stb_q;
  logic stb_s, stb_fall;
  logic master, own_load, slave_load, word_en;
  logic [DW-1:0] word_q, word_d;

  rcw_rst_sync #(.STAGES(SYNC)) i_por_sync (
    .clk(clk), .arst_n(por_n), .rst_n(por_rst_n));

  rcw_rst_sync #(.STAGES(SYNC)) i_hrst_sync (
    .clk(clk), .arst_n(hrst_n & por_n), .rst_n(hrst_rst_n));

  assign seq_rst_n = por_rst_n & hrst_rst_n;

  // strobe synchroniser plus edge stage, no reset so it fills during reset
  always_ff @(posedge clk) begin
    stb_q <= {stb_q[SYNC-1:0], cfg_stb_i};
  end
  assign stb_s    = stb_q[SYNC-1];
  assign stb_fall = stb_q[SYNC] & ~stb_q[SYNC-1];

  rcw_fetch #(
    .DW(DW), .AW(AW), .NWORDS(NWORDS), .BASE_ADDR(BASE_ADDR)
  ) i_fetch (
    .clk(clk), .seq_rst_n(seq_rst_n), .por_rst_n(por_rst_n),
    .stb_s(stb_s), .rd_ack(rd_ack_i), .rd_data(rd_data_i),
    .rd_req(rd_req_o), .rd_addr(rd_addr_o), .sel(sel_o),
    .data(cfg_data_o), .done(done_o), .master(master));

  assign own_load   = master & sel_o[0];
  assign slave_load = seq_rst_n & done_o & ~master & stb_fall;
  assign word_en    = own_load | slave_load;
  assign word_d     = own_load ? cfg_data_o : cfg_data_i;

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n)    word_q <= '0;
    else if (word_en)  word_q <= word_d;
  end

  assign cfg_word_o = word_q;
  assign rst_hold_o = ~done_o;

  rcw_decode #(.DW(DW)) i_decode (
    .word(word_q), .earb(earb_o), .ext_memc(ext_memc_o),
    .core_dis(core_dis_o), .ext_bus_mode(ext_bus_mode_o),
    .bank0_width(bank0_width_o));
endmodule

// File: rtl/rcw_seq_chk.sv
module rcw_seq_chk #(
  parameter int DW     = 32,
  parameter int NWORDS = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              hrst_n,
  input logic              rd_req_o,
  input logic              rd_ack_i,
  input logic [NWORDS-1:0] sel_o,
  input logic              done_o,
  input logic              rst_hold_o,
  input logic [DW-1:0]     cfg_word_o
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(sel_o)); // R5

  AST_SEL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!por_n || !hrst_n)
    (sel_o != '0) |=> (sel_o == '0)); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!por_n || !hrst_n)
    (rd_req_o && !rd_ack_i) |=> rd_req_o); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    done_o |=> done_o); // R7

  AST_NO_SEL_WHEN_DONE: assert property (@(posedge clk) disable iff (!por_n)
    done_o |-> (sel_o == '0 && !rd_req_o)); // R7

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!por_n)
    (sel_o != '0) |-> rst_hold_o); // R7

  AST_WORD_KEPT_HRST: assert property (@(posedge clk) disable iff (!por_n)
    !hrst_n |=> $stable(cfg_word_o)); // R8
endmodule

bind rcw_seq rcw_seq_chk #(.DW(DW), .NWORDS(NWORDS)) i_chk (
  .clk(clk), .por_n(por_n), .hrst_n(hrst_n), .rd_req_o(rd_req_o),
  .rd_ack_i(rd_ack_i), .sel_o(sel_o), .done_o(done_o),
  .rst_hold_o(rst_hold_o), .cfg_word_o(cfg_word_o));

// File: tb/test_rcw_seq.sv
module test_rcw_seq;
  localparam int DW = 32, AW = 16, NW = 8;
  localparam logic [AW-1:0] BASE = 16'h0100;

  logic clk = 1'b0;
  logic por_n, hrst_n, cfg_stb_i, rd_ack_i;
  logic [DW-1:0] cfg_data_i, rd_data_i;
  logic rd_req_o, done_o, rst_hold_o;
  logic [AW-1:0] rd_addr_o;
  logic [NW-1:0] sel_o;
  logic [DW-1:0] cfg_data_o, cfg_word_o;
  logic earb_o, ext_memc_o, core_dis_o, ext_bus_mode_o;
  logic [6:0] bank0_width_o;

  always #10 clk = ~clk;

  rcw_seq #(.DW(DW), .AW(AW), .NWORDS(NW), .BASE_ADDR(BASE)) i_rcw_seq (.*);

  int n_run = 0, n_fail = 0;
  int n_reads = 0, n_pulses = 0, wait_cnt = 0;

  typedef struct { int idx; logic [DW-1:0] data; } exp_t;
  exp_t sb_q[$];

  function automatic logic [DW-1:0] mem_word(int k);
    return 32'hD400_0000 + k * 32'h0012_3457;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // boot memory model (driver): pushes expected select items at acknowledge
  always @(negedge clk) begin
    if (rd_ack_i) rd_ack_i = 1'b0;
    else if (rd_req_o) begin
      if (wait_cnt == 0) begin
        chk(rd_addr_o == BASE + AW'(n_reads), "R4 address", DW'(rd_addr_o),
            DW'(BASE + AW'(n_reads)));
        rd_data_i = mem_word(n_reads);
        rd_ack_i  = 1'b1;
        sb_q.push_back('{idx: n_reads, data: mem_word(n_reads)});
        n_reads++;
        wait_cnt = n_reads % 3;
      end else wait_cnt--;
    end
  end

  // monitor: one select pulse per expected item
  always @(negedge clk) begin
    if (sel_o != '0) begin
      n_pulses++;
      if (sb_q.size() == 0) chk(1'b0, "R5 unexpected pulse", DW'(sel_o), 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(sel_o == NW'(1 << e.idx), "R5 select bit", DW'(sel_o), DW'(1 << e.idx));
        chk(cfg_data_o == e.data, "R5 data", cfg_data_o, e.data);
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic por_cycle(input logic stb);
    cfg_stb_i = stb;
    por_n = 1'b0;
    cycles(5);
    por_n = 1'b1;
  endtask

  task automatic slave_pulse(input logic [DW-1:0] w);
    cfg_data_i = w;
    cycles(1);
    cfg_stb_i = 1'b0;
    cycles(3);
    cfg_stb_i = 1'b1;
    cycles(6);
  endtask

  task automatic chk_fields(input string tag, input logic [3:0] flags, input int width);
    chk({earb_o, ext_memc_o, core_dis_o, ext_bus_mode_o} == flags, {"R9 flags ", tag},
        DW'({earb_o, ext_memc_o, core_dis_o, ext_bus_mode_o}), DW'(flags));
    chk(bank0_width_o == 7'(width), {"R10 width ", tag}, DW'(bank0_width_o), DW'(width));
  endtask

  initial begin
    #(20 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    hrst_n = 1'b1; rd_ack_i = 1'b0; rd_data_i = '0; cfg_data_i = '0;
    cfg_stb_i = 1'b1; por_n = 1'b0;
    cycles(5);
    // reset state
    chk(!done_o && rst_hold_o, "R7 reset done/hold", DW'({done_o, rst_hold_o}), 32'h1);
    chk(sel_o == '0 && !rd_req_o, "R7 reset idle", DW'({sel_o, rd_req_o}), 0);
    chk(cfg_word_o == '0, "R2 reset word", cfg_word_o, 0);

    // non-master, default word
    por_n = 1'b1;
    cycles(4);
    chk(done_o && !rst_hold_o, "R1 non-master done", DW'({done_o, rst_hold_o}), 32'h2);
    chk(cfg_word_o == '0, "R2 default word", cfg_word_o, 0);
    chk_fields("default", 4'b0000, 64);

    // slave captures
    slave_pulse(32'h2C00_0000);
    chk(cfg_word_o == 32'h2C00_0000, "R3 slave capture", cfg_word_o, 32'h2C00_0000);
    chk_fields("slave A", 4'b0010, 32);
    slave_pulse(32'h3800_0000);
    chk(cfg_word_o == 32'h3800_0000, "R3 second capture", cfg_word_o, 32'h3800_0000);
    chk_fields("slave B", 4'b0011, 16);
    chk(n_reads == 0, "R1 no reads as non-master", DW'(n_reads), 0);

    // hard reset keeps word and done
    cfg_data_i = 32'hFFFF_FFFF;
    hrst_n = 1'b0;
    cycles(3);
    chk(done_o == 1'b1, "R8 done during hard reset", DW'(done_o), 1);
    hrst_n = 1'b1;
    cycles(6);
    chk(cfg_word_o == 32'h3800_0000, "R8 word kept", cfg_word_o, 32'h3800_0000);
    chk(done_o && n_reads == 0, "R8 no reads after hard reset", DW'(n_reads), 0);

    // power-on reset reloads zero
    por_cycle(1'b1);
    cycles(4);
    chk(cfg_word_o == '0, "R8 POR reload", cfg_word_o, 0);

    // master sequence
    n_reads = 0; n_pulses = 0; wait_cnt = 0;
    por_cycle(1'b0);
    for (int c = 0; c < 300 && !done_o; c++) begin
      chk(rst_hold_o == 1'b1, "R7 hold while busy", DW'(rst_hold_o), 1);
      cycles(1);
    end
    chk(done_o == 1'b1, "R7 master done", DW'(done_o), 1);
    chk(n_pulses == NW, "R5 pulse count", DW'(n_pulses), NW);
    chk(n_reads == NW, "R4 read count", DW'(n_reads), NW);
    chk(sb_q.size() == 0, "R5 scoreboard empty", DW'(sb_q.size()), 0);
    chk(cfg_word_o == mem_word(0), "R6 own word", cfg_word_o, mem_word(0));
    chk_fields("master", 4'b1101, 8);
    cycles(20);
    chk(n_reads == NW && done_o, "R4 exactly eight", DW'(n_reads), NW);

    // hard reset after master completion
    hrst_n = 1'b0;
    cycles(3);
    hrst_n = 1'b1;
    cycles(10);
    chk(cfg_word_o == mem_word(0), "R8 master word kept", cfg_word_o, mem_word(0));
    chk(n_reads == NW && done_o, "R8 no refetch", DW'(n_reads), NW);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule